// File: doc/BRIEF.md
# Memory BIST pattern sequencer

This block is a built-in self-test sequencer for a synchronous single-port word memory with one cycle of read latency. A start pulse launches a chosen set of march-style tests over an inclusive address window. Each test is a series of passes. A pass first writes every location in the window and then reads every location back. For most tests the data written depends on the address: each location gets one of two patterns, picked by a selector bit taken from the address.

In the read sweep of every pattern pass, the normal check is followed by three more steps at the same location. The location is written with the complement of its data, read back and checked, and then restored. The restore means the memory ends each pass holding the pass's own background.

A mismatch pulses an error strobe. The strobe carries the failing address, the expected word, the word read and a code that identifies the test. Three controls govern the run: a loop control repeats the current test, a halt control pauses after each test, and an error-stop control freezes the sequencer on a mismatch. A continue pulse releases either kind of pause.

Top module: `mbist_seq`

## Requirements
- R1: The mask is `test_sel` (bit i selects test i). An all-zero mask runs tests 0 to 3. Selected tests run in rising index order. Bit 4 starts no test, so a mask of 5'b10000 finishes with no memory writes.
- R2: Test 0 (address test) has four steps. It writes each location with its zero-extended address, then reads and checks every location. It then writes each location with the complement of that value, then reads and checks every location again. It makes 2N writes for an N-word window, and the memory is left holding the complemented addresses.
- R3: Writes go only to addresses from `first_addr` to `last_addr` inclusive. Every pass writes the whole window before it reads any of it.
- R4: In tests 1 to 3, each read check is followed by three steps: a write of the complement, a read and check of the complement, and a write that restores the value. One pass therefore makes 3N writes.
- R5: In tests 1 to 3, a location whose selector bit is 1 receives pattern P1, and one whose selector is 0 receives P2. Test 1 selects on address bit 0. Its first pass uses (P1,P2) = (0x0000, 0xFFFF) and its second pass uses the swapped pair, so the memory ends with 0xFFFF at odd addresses and 0x0000 at even addresses.
- R6: Test 2 uses the same two passes as test 1 but a different selector. With `mem_kind`=0 the selector is address bit 5 XOR address bit 6. With `mem_kind`=1 it is address bit 6 alone.
- R7: Test 3 selects on address bit 0 and runs two subtests of 16 iterations each. The walking word starts at 0x0001 in the first subtest and at 0xFFFE in the second, and it rotates left by one place each iteration. The other pattern is 0x0000 in the first subtest and 0xFFFF in the second. Each iteration runs one pass with (P1,P2) = (other, walk) and then one with (walk, other). The memory ends with 0x7FFF at odd addresses and 0xFFFF at even addresses, after 64 passes.
- R8: A mismatch raises `err` for one compare cycle. In that cycle `err_addr`, `err_exp` and `err_act` show the failing address, the expected word and the word read. `err_code` shows 0x10, 0x18 or 0x20 for tests 0 to 2, and 0x28 or 0x2A for the first or second subtest of test 3.
- R9: A compare takes place in the cycle after the read address is issued. `mem_we` and `cmp_valid` are never high in the same cycle.
- R10: While `loop_test` is high at the end of a test, that test starts again from its first pass.
- R11: With `halt_each` high, the sequencer raises `paused` after each test and makes no writes until a `cont` pulse arrives.
- R12: With `err_stop` high, a mismatch freezes the sequencer from the next cycle. While frozen, `paused` is high and there are no writes and no compares, until a `cont` pulse arrives. With `err_stop` low, testing continues past mismatches.
- R13: After reset, `busy`, `done`, `mem_we` and `err` are low. `done` rises and `busy` falls after the last selected test, and `done` clears on the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run (accepted when idle) |
| first_addr | input | AW | Lowest address of the window |
| last_addr | input | AW | Highest address of the window |
| test_sel | input | 5 | Test selection mask |
| mem_kind | input | 1 | Selector equation for test 2 |
| loop_test | input | 1 | Repeat the current test |
| halt_each | input | 1 | Pause after each test |
| err_stop | input | 1 | Freeze on mismatch |
| cont | input | 1 | Release a pause or a freeze |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data, one cycle after the address |
| cmp_valid | output | 1 | Read data is compared this cycle |
| err | output | 1 | Mismatch strobe |
| err_addr | output | AW | Failing address |
| err_exp | output | DW | Expected word |
| err_act | output | DW | Word read |
| err_code | output | 8 | Test code of the mismatch |
| busy | output | 1 | Run in progress |
| paused | output | 1 | Halted after a test, or frozen on an error |
| done | output | 1 | Last selected test has finished |

## Verification
A write takes effect in the model memory at the edge where `mem_we` is high. Read data comes back one edge after the address is issued. The error fields are combinational in the compare cycle, so the bench samples `err` and its fields on the falling edge that lies inside that cycle. A freeze or a halt becomes visible on the falling edge after the edge that entered it, and the bench checks `paused` and the write count from that point on. Final memory contents, write totals and the order of error codes are read only after `done` rises, and by then every write of the run has landed.

// File: rtl/mbist_seq.sv
module mbist_seq #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  input  logic [4:0]    test_sel,
  input  logic          mem_kind,
  input  logic          loop_test,
  input  logic          halt_each,
  input  logic          err_stop,
  input  logic          cont,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic          cmp_valid,
  output logic          err,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_act,
  output logic [7:0]    err_code,
  output logic          busy,
  output logic          paused,
  output logic          done
);

  localparam int KW = $clog2(DW);
  localparam int SW = KW + 2;
  localparam logic [SW-1:0] BIT_LAST = SW'(4*DW-1);

  typedef enum logic [3:0] {IDLE, WR, RA, RC, CW, CR, CC, RS, ENDP, PAUSE} st_t;

  st_t           st;
  logic [3:0]    run_m;
  logic [1:0]    tst;
  logic [SW-1:0] step;
  logic [AW-1:0] addr, fa, la;
  logic          frozen, done_q;

  logic          sub, half, sel, mismatch, at_last;
  logic [KW-1:0] rot;
  logic [DW-1:0] base, other, walk, p1, p2, pat, exp_w;
  logic [2*DW-1:0] dbl;
  logic [3:0]    em4;
  logic [1:0]    nxt, fst;
  logic          nxt_ok, fst_ok;
  logic [SW-1:0] last_step;

  assign sub   = step[SW-1];
  assign half  = step[0];
  assign rot   = step[KW:1];
  assign base  = sub ? {{(DW-1){1'b1}}, 1'b0} : {{(DW-1){1'b0}}, 1'b1};
  assign other = sub ? '1 : '0;
  assign dbl   = {base, base} << rot;
  assign walk  = dbl[2*DW-1:DW];

  always_comb begin
    if (tst == 2'd3) begin
      p1 = half ? walk : other;
      p2 = half ? other : walk;
    end else begin
      p1 = step[0] ? '1 : '0;
      p2 = ~p1;
    end
  end

  assign sel = (tst == 2'd2) ? (mem_kind ? addr[6] : (addr[5] ^ addr[6])) : addr[0];

  always_comb begin
    if (tst == 2'd0) pat = step[0] ? ~{{(DW-AW){1'b0}}, addr} : {{(DW-AW){1'b0}}, addr};
    else             pat = sel ? p1 : p2;
  end

  assign exp_w     = (st == CC) ? ~pat : pat;
  assign mem_addr  = addr;
  assign mem_wdata = (st == CW) ? ~pat : pat;
  assign mem_we    = (st == WR || st == CW || st == RS) && !frozen;
  assign cmp_valid = (st == RC || st == CC) && !frozen;
  assign mismatch  = cmp_valid && (mem_rdata != exp_w);
  assign err       = mismatch;
  assign err_addr  = addr;
  assign err_exp   = exp_w;
  assign err_act   = mem_rdata;
  assign err_code  = (tst == 2'd0) ? 8'h10 :
                     (tst == 2'd1) ? 8'h18 :
                     (tst == 2'd2) ? 8'h20 : (sub ? 8'h2A : 8'h28);
  assign busy      = (st != IDLE);
  assign paused    = (st == PAUSE) || frozen;
  assign done      = done_q;
  assign at_last   = (addr == la);
  assign last_step = (tst == 2'd3) ? BIT_LAST : SW'(1);
  assign em4       = (test_sel == 5'd0) ? 4'hF : test_sel[3:0];

  always_comb begin
    nxt_ok = 1'b0; nxt = tst;
    fst_ok = 1'b0; fst = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (run_m[i] && i > int'(tst)) begin nxt_ok = 1'b1; nxt = 2'(i); end
      if (em4[i]) begin fst_ok = 1'b1; fst = 2'(i); end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; run_m <= '0; tst <= '0; step <= '0;
      addr <= '0; fa <= '0; la <= '0; frozen <= 1'b0; done_q <= 1'b0;
    end else if (frozen) begin
      if (cont) frozen <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          run_m <= em4; fa <= first_addr; la <= last_addr;
          addr <= first_addr; step <= '0;
          if (fst_ok) begin tst <= fst; st <= WR; done_q <= 1'b0; end
          else done_q <= 1'b1;
        end
        WR: if (at_last) begin addr <= fa; st <= RA; end
            else addr <= addr + 1'b1;
        RA: st <= RC;
        RC: begin
          if (mismatch && err_stop) frozen <= 1'b1;
          if (tst != 2'd0) st <= CW;
          else if (at_last) st <= ENDP;
          else begin addr <= addr + 1'b1; st <= RA; end
        end
        CW: st <= CR;
        CR: st <= CC;
        CC: begin
          if (mismatch && err_stop) frozen <= 1'b1;
          st <= RS;
        end
        RS: if (at_last) st <= ENDP;
            else begin addr <= addr + 1'b1; st <= RA; end
        ENDP: begin
          addr <= fa;
          if (step != last_step) begin step <= step + 1'b1; st <= WR; end
          else if (loop_test) begin step <= '0; st <= WR; end
          else if (halt_each) st <= PAUSE;
          else if (nxt_ok) begin tst <= nxt; step <= '0; st <= WR; end
          else begin st <= IDLE; done_q <= 1'b1; end
        end
        PAUSE: if (cont) begin
          if (nxt_ok) begin tst <= nxt; step <= '0; st <= WR; end
          else begin st <= IDLE; done_q <= 1'b1; end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbist_seq_chk.sv
module mbist_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic          cmp_valid,
  input logic          err,
  input logic          err_stop,
  input logic          paused,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] first_addr,
  input logic [AW-1:0] last_addr
);

  AST_WE_OR_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && cmp_valid)); // R9

  AST_CMP_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $stable(mem_addr)); // R9

  AST_ERR_ON_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cmp_valid); // R8

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= first_addr && mem_addr <= last_addr)); // R3

  AST_FREEZE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err && err_stop) |=> (paused && !mem_we && !cmp_valid)); // R12

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!mem_we && !cmp_valid)); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R13

endmodule

bind mbist_seq mbist_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .cmp_valid(cmp_valid),
  .err(err), .err_stop(err_stop), .paused(paused), .busy(busy), .done(done),
  .mem_addr(mem_addr), .first_addr(first_addr), .last_addr(last_addr)
);

// File: tb/test_mbist_seq.sv
module test_mbist_seq;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, mem_kind = 0, loop_test = 0, halt_each = 0, err_stop = 0, cont = 0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic [4:0] test_sel = '0;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_act;
  logic [7:0] err_code;
  logic mem_we, cmp_valid, err, busy, paused, done;

  always #2 clk = ~clk;

  mbist_seq #(.AW(AW), .DW(DW)) i_mbist_seq (.*);

  logic [DW-1:0] mem [0:4095];
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_mask = '0;
  int wcnt = 0, oor = 0, errs = 0, ncodes = 0;
  logic [7:0] codes [0:7];
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_exp, e_act;
  logic [7:0] e_code;
  int nchk = 0, nfail = 0;

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr] | ((mem_addr == flt_addr) ? flt_mask : '0);
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wcnt <= wcnt + 1;
      if (mem_addr < first_addr || mem_addr > last_addr) oor <= oor + 1;
    end
  end

  always @(negedge clk) if (err) begin
    if (errs == 0) begin e_addr = err_addr; e_exp = err_exp; e_act = err_act; e_code = err_code; end
    errs++;
    if (ncodes < 8 && (ncodes == 0 || codes[ncodes-1] != err_code)) begin
      codes[ncodes] = err_code; ncodes++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  task automatic prep(input logic [4:0] s, input int lo, input int hi, input logic kind);
    @(negedge clk);
    for (int a = 0; a < 256; a++) mem[a] = 16'hA5A5;
    test_sel = s; first_addr = AW'(lo); last_addr = AW'(hi); mem_kind = kind;
    wcnt = 0; oor = 0; errs = 0; ncodes = 0;
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 100000 && !done; n++) @(negedge clk);
  endtask

  task automatic wait_paused();
    for (int n = 0; n < 100000 && !paused; n++) @(negedge clk);
  endtask

  task automatic pulse_cont();
    cont = 1; @(negedge clk); cont = 0;
  endtask

  task automatic t_reset();
    check(!busy && !done && !mem_we && !err, "R13 reset", {busy, done, mem_we, err}, 0);
  endtask

  task automatic t_addr();
    int bad = 0;
    prep(5'b00001, 10, 20, 0);
    wait_done();
    check(done && !busy, "R13 done", {done, busy}, 2);
    check(wcnt == 22, "R2 writes", wcnt, 22);
    for (int a = 10; a <= 20; a++) if (mem[a] != ~DW'(a)) bad++;
    check(bad == 0, "R2 content", bad, 0);
    check(mem[9] == 16'hA5A5 && mem[21] == 16'hA5A5 && oor == 0, "R3 window", oor, 0);
    check(errs == 0, "R8 no error", errs, 0);
  endtask

  task automatic t_col();
    int bad = 0;
    prep(5'b00010, 0, 9, 0);
    wait_done();
    check(wcnt == 60, "R4 writes", wcnt, 60);
    for (int a = 0; a <= 9; a++) if (mem[a] != (a[0] ? 16'hFFFF : 16'h0000)) bad++;
    check(bad == 0, "R5 content", bad, 0);
  endtask

  task automatic t_word(input logic kind);
    int bad = 0;
    prep(5'b00100, 0, 127, kind);
    wait_done();
    check(wcnt == 768, "R4 word writes", wcnt, 768);
    for (int a = 0; a <= 127; a++) begin
      logic s;
      s = kind ? a[6] : (a[5] ^ a[6]);
      if (mem[a] != (s ? 16'hFFFF : 16'h0000)) bad++;
    end
    check(bad == 0, "R6 content", bad, 0);
  endtask

  task automatic t_bit();
    int bad = 0;
    prep(5'b01000, 0, 7, 0);
    wait_done();
    check(wcnt == 1536, "R7 writes", wcnt, 1536);
    for (int a = 0; a <= 7; a++) if (mem[a] != (a[0] ? 16'h7FFF : 16'hFFFF)) bad++;
    check(bad == 0, "R7 content", bad, 0);
  endtask

  task automatic t_order();
    flt_addr = 5; flt_mask = 16'h0004;
    prep(5'b00000, 0, 7, 0);
    wait_done();
    check(ncodes == 5, "R1 default tests", ncodes, 5);
    check(codes[0] == 8'h10 && codes[1] == 8'h18 && codes[2] == 8'h20, "R8 codes 0-2",
          {codes[0], codes[1], codes[2]}, 24'h101820);
    check(codes[3] == 8'h28 && codes[4] == 8'h2A, "R8 codes bit", {codes[3], codes[4]}, 16'h282A);
    prep(5'b00101, 0, 7, 0);
    wait_done();
    check(ncodes == 2 && codes[0] == 8'h10 && codes[1] == 8'h20, "R1 order", {codes[0], codes[1]}, 16'h1020);
    flt_mask = 0;
  endtask

  task automatic t_none();
    prep(5'b10000, 0, 7, 0);
    repeat (3) @(negedge clk);
    check(done && !busy && wcnt == 0, "R1 bit4 only", wcnt, 0);
  endtask

  task automatic t_err();
    int w;
    flt_addr = 5; flt_mask = 16'h0004; err_stop = 1;
    prep(5'b00010, 0, 7, 0);
    for (int n = 0; n < 10000 && !err; n++) @(negedge clk);
    check(err_addr == 5 && err_exp == 0 && err_act == 16'h0004, "R9 R8 fields",
          {err_addr, err_exp, err_act}, {12'd5, 16'h0, 16'h4});
    check(err_code == 8'h18, "R8 code", err_code, 8'h18);
    @(negedge clk);
    check(paused && !mem_we, "R12 frozen", {paused, mem_we}, 2);
    w = wcnt;
    repeat (5) @(negedge clk);
    check(paused && wcnt == w, "R12 held", wcnt, w);
    for (int n = 0; n < 10000 && !done; n++) begin
      if (paused) pulse_cont(); else @(negedge clk);
    end
    check(done && errs == 2, "R8 error count", errs, 2);
    err_stop = 0;
    prep(5'b00010, 0, 7, 0);
    wait_done();
    check(done && errs == 2 && wcnt == 48, "R12 continue", errs, 2);
    flt_mask = 0;
  endtask

  task automatic t_loop();
    loop_test = 1;
    prep(5'b00010, 0, 3, 0);
    repeat (300) @(negedge clk);
    check(busy && !done && wcnt > 24, "R10 repeats", wcnt, 25);
    loop_test = 0;
    wait_done();
    check(done, "R10 exit", done, 1);
  endtask

  task automatic t_halt();
    halt_each = 1;
    prep(5'b00011, 0, 3, 0);
    wait_paused();
    check(paused && !done && wcnt == 8, "R11 halt after test0", wcnt, 8);
    repeat (4) @(negedge clk);
    check(paused && wcnt == 8, "R11 held", wcnt, 8);
    pulse_cont();
    wait_paused();
    check(paused && wcnt == 32, "R11 halt after test1", wcnt, 32);
    pulse_cont();
    wait_done();
    halt_each = 0;
    check(done && !busy, "R13 done after halt", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_addr();
    t_col();
    t_word(0);
    t_word(1);
    t_bit();
    t_order();
    t_none();
    t_err();
    t_loop();
    t_halt();
    summary();
  end
endmodule